// File: doc/BRIEF.md
# Big-Endian Bus Width Adapter

This block connects a 32-bit internal access port to an external memory bus whose data width is chosen per access: 8, 16 or 32 bits. A requester presents a byte, 16-bit word or 32-bit longword access with an address, a direction and, for writes, right-justified write data. The adapter drives the data onto the correct external byte lanes in big-endian order, with one active-low write strobe per lane. For reads it drives a single active-low read strobe.

When the device is narrower than the access, the adapter splits the access into a run of external cycles. The most significant part goes first, at the lowest address. On reads it assembles the returned lanes into a right-justified result. Each external cycle lasts one clock and is followed by one clock with every strobe high. The requester holds its request steady until the one-clock `done` pulse. A misaligned or illegal request ends with `done` and `err` and issues no external cycle.

Top module: `bus_width_adapter`

## Requirements
- R1: With a 32-bit device (`dev_width`=2), a byte access (`req_size`=0) at address offset k (0..3) uses data bits [31-8k -: 8] and drives only write strobe `ext_we_n[3-k]` low. Strobe bit 3 belongs to D31..D24 and bit 0 to D7..D0.
- R2: With a 32-bit device, a word access (`req_size`=1) at offset 0 uses D31..D16 with `ext_we_n`=4'b0011, and at offset 2 uses D15..D0 with 4'b1100. A longword (`req_size`=2) uses D31..D0 with 4'b0000, all in one external cycle.
- R3: With a 16-bit device (`dev_width`=1), a byte at an even address uses D15..D8 and strobe bit 1, and a byte at an odd address uses D7..D0 and strobe bit 0. A word takes one cycle on D15..D0. A longword takes two cycles: bits 31:16 at the request address, then bits 15:0 at address+2.
- R4: With an 8-bit device (`dev_width`=0), every byte travels on D7..D0 with strobe bit 0. A word takes two cycles and a longword takes four, most significant byte first, with the address stepping by 1 each cycle.
- R5: A read returns the accessed bytes right-justified on `rdata` during the `done` cycle, with the byte at the lowest address most significant. Each cycle's lanes are sampled at the clock edge that ends that cycle, and lanes outside the access are ignored.
- R6: The first external cycle starts in the clock after the request is accepted. `done` is high for exactly one clock, the clock right after the last external cycle.
- R7: Outside an external cycle, `ext_rd_n` is 1, `ext_we_n` is 4'hF, and `ext_addr` and `ext_wdata` are 0. Consecutive cycles of a split access are separated by one such clock, and read and write strobes are never low together.
- R8: Any of the following makes the adapter pulse `done` with `err` in the clock after acceptance, with no external cycle: a word at an odd address, a longword not on a 4-byte boundary, `req_size`=3 or `dev_width`=3.
- R9: In reset, all strobes are high, `done` and `err` are low and `rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; held until `done` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 word, 2 longword, 3 illegal |
| req_addr | input | AW | Byte address of the access |
| req_wdata | input | 32 | Right-justified write data |
| dev_width | input | 2 | 0 = 8-bit, 1 = 16-bit, 2 = 32-bit device, 3 illegal |
| ext_rdata | input | 32 | Data lanes returned by the device |
| done | output | 1 | One-clock completion pulse |
| err | output | 1 | Rejection flag, valid with `done` |
| rdata | output | 32 | Right-justified read result, valid with `done` |
| ext_addr | output | AW | Byte address of the current external cycle |
| ext_wdata | output | 32 | Data lanes driven in a write cycle |
| ext_we_n | output | 4 | Active-low per-lane write strobes, bit 3 = D31..D24 |
| ext_rd_n | output | 1 | Active-low read strobe |

## Verification
The hardest cases to reach are the multi-cycle splits: a longword read on an 8-bit device, and a word or longword split across a 16-bit device. Here every beat has to pick a different slice, address and lane, and the read result only shows up after the last beat. The bench keeps a byte-addressed memory model. It first writes known patterns through one device width, then reads them back through another, so each split beat returns distinct bytes. On narrow devices the bench also fills the unused upper lanes with a filler value, so any lane the adapter takes by mistake shows up in the assembled result.

// File: rtl/bwa_pkg.sv
package bwa_pkg;
    localparam int LANES = 4;
    localparam int BUS_W = 8 * LANES;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACT  = 2'd1,
        ST_GAP  = 2'd2,
        ST_DONE = 2'd3
    } bwa_state_e;

    typedef struct packed {
        bwa_state_e        st;
        logic [1:0]        beat;
        logic              err;
        logic [BUS_W-1:0]  acc;
    } bwa_ctl_s;

    function automatic logic [2:0] width_bytes(input logic [1:0] code);
        case (code)
            2'd0:    width_bytes = 3'd1;
            2'd1:    width_bytes = 3'd2;
            default: width_bytes = 3'd4;
        endcase
    endfunction
endpackage

// File: rtl/bwa_lane_map.sv
module bwa_lane_map
    import bwa_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [1:0]       size_i,
    input  logic [1:0]       dwid_i,
    input  logic [AW-1:0]    addr_i,
    input  logic [1:0]       beat_i,
    input  logic [BUS_W-1:0] wdata_i,
    output logic             illegal_o,
    output logic             last_o,
    output logic [AW-1:0]    beat_addr_o,
    output logic [2:0]       lane_lo_o,
    output logic [2:0]       bw_o,
    output logic [LANES-1:0] lane_mask_o,
    output logic [BUS_W-1:0] lane_wdata_o
);
    logic [2:0]       acc_b;
    logic [2:0]       dev_b;
    logic [2:0]       offs;
    logic [3:0]       base_b;
    logic [3:0]       sent_b;
    logic [3:0]       rem_b;
    logic [LANES-1:0] mask0;
    logic [BUS_W-1:0] bw_bits;
    logic [BUS_W-1:0] chunk;

    always_comb begin
        acc_b       = width_bytes(size_i);
        dev_b       = width_bytes(dwid_i);
        illegal_o   = (size_i == 2'd3) || (dwid_i == 2'd3)
                   || ((addr_i[1:0] & (acc_b[1:0] - 2'd1)) != 2'd0);
        // bytes moved per external cycle
        bw_o        = (acc_b < dev_b) ? acc_b : dev_b;
        base_b      = {2'b00, beat_i} * {1'b0, bw_o};
        sent_b      = base_b + {1'b0, bw_o};
        last_o      = (sent_b == {1'b0, acc_b});
        beat_addr_o = addr_i + AW'(base_b);
        // big-endian: lowest address sits on the highest lane of the device
        offs        = {1'b0, beat_addr_o[1:0] & (dev_b[1:0] - 2'd1)};
        lane_lo_o   = dev_b - offs - bw_o;
        rem_b       = {1'b0, acc_b} - sent_b;
        case (bw_o)
            3'd1:    begin mask0 = 4'b0001; bw_bits = 32'h0000_00FF; end
            3'd2:    begin mask0 = 4'b0011; bw_bits = 32'h0000_FFFF; end
            default: begin mask0 = 4'b1111; bw_bits = 32'hFFFF_FFFF; end
        endcase
        chunk        = (wdata_i >> {rem_b, 3'b000}) & bw_bits;
        lane_mask_o  = mask0 << lane_lo_o;
        lane_wdata_o = chunk << {lane_lo_o, 3'b000};
    end
endmodule

// File: rtl/bwa_rd_pack.sv
module bwa_rd_pack
    import bwa_pkg::*;
(
    input  logic [BUS_W-1:0] acc_i,
    input  logic [BUS_W-1:0] ext_rdata_i,
    input  logic [LANES-1:0] lane_mask_i,
    input  logic [2:0]       lane_lo_i,
    input  logic [2:0]       bw_i,
    output logic [BUS_W-1:0] acc_o
);
    logic [BUS_W-1:0] byte_en;
    logic [BUS_W-1:0] chunk;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign byte_en[8*g +: 8] = {8{lane_mask_i[g]}};
    end

    always_comb begin
        chunk = (ext_rdata_i & byte_en) >> {lane_lo_i, 3'b000};
        if (bw_i >= 3'd4) acc_o = chunk;
        else              acc_o = (acc_i << {bw_i[1:0], 3'b000}) | chunk;
    end
endmodule

// File: rtl/bus_width_adapter.sv
module bus_width_adapter
    import bwa_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [1:0]       req_size,
    input  logic [AW-1:0]    req_addr,
    input  logic [BUS_W-1:0] req_wdata,
    input  logic [1:0]       dev_width,
    input  logic [BUS_W-1:0] ext_rdata,
    output logic             done,
    output logic             err,
    output logic [BUS_W-1:0] rdata,
    output logic [AW-1:0]    ext_addr,
    output logic [BUS_W-1:0] ext_wdata,
    output logic [LANES-1:0] ext_we_n,
    output logic             ext_rd_n
);
    bwa_ctl_s         s_q, s_d;
    logic             illegal, last;
    logic [AW-1:0]    beat_addr;
    logic [2:0]       lane_lo, bw;
    logic [LANES-1:0] lane_mask;
    logic [BUS_W-1:0] lane_wdata, acc_next;
    logic             active;

    bwa_lane_map #(.AW(AW)) u_map (
        .size_i(req_size), .dwid_i(dev_width), .addr_i(req_addr),
        .beat_i(s_q.beat), .wdata_i(req_wdata),
        .illegal_o(illegal), .last_o(last), .beat_addr_o(beat_addr),
        .lane_lo_o(lane_lo), .bw_o(bw), .lane_mask_o(lane_mask),
        .lane_wdata_o(lane_wdata)
    );

    bwa_rd_pack u_pack (
        .acc_i(s_q.acc), .ext_rdata_i(ext_rdata), .lane_mask_i(lane_mask),
        .lane_lo_i(lane_lo), .bw_i(bw), .acc_o(acc_next)
    );

    always_comb begin
        s_d = s_q;
        case (s_q.st)
            ST_IDLE: if (req_valid) begin
                s_d.beat = 2'd0;
                s_d.acc  = '0;
                s_d.err  = illegal;
                s_d.st   = illegal ? ST_DONE : ST_ACT;
            end
            ST_ACT: begin
                if (!req_write) s_d.acc = acc_next;
                if (last) begin
                    s_d.st = ST_DONE;
                end else begin
                    s_d.st   = ST_GAP;
                    s_d.beat = s_q.beat + 2'd1;
                end
            end
            ST_GAP:  s_d.st = ST_ACT;
            default: begin
                s_d.st  = ST_IDLE;
                s_d.err = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: ST_IDLE, beat: 2'd0, err: 1'b0, acc: '0};
        else        s_q <= s_d;
    end

    always_comb begin
        active    = (s_q.st == ST_ACT);
        ext_addr  = active ? beat_addr : '0;
        ext_we_n  = (active && req_write) ? ~lane_mask : '1;
        ext_wdata = (active && req_write) ? lane_wdata : '0;
        ext_rd_n  = !(active && !req_write);
        done      = (s_q.st == ST_DONE);
        err       = done && s_q.err;
        rdata     = s_q.acc;
    end

    // R7: a strobe cycle is always followed by a clock with every strobe high
    p_gap_after_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_rd_n || ext_we_n != 4'hF) |=> (ext_rd_n && ext_we_n == 4'hF));

    // R7: read and write strobes never low together
    p_rw_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ext_rd_n && ext_we_n != 4'hF));

    // R6: done lasts exactly one clock
    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: a good completion comes right after an external cycle
    p_done_after_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> $past(!ext_rd_n || ext_we_n != 4'hF));

    // R8: a rejected request issued no external cycle
    p_err_no_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> ($past(ext_rd_n) && $past(ext_we_n) == 4'hF));

    // R1: a byte write on any device enables exactly one lane
    p_byte_one_lane_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_we_n[0] || !ext_we_n[1] || !ext_we_n[2] || !ext_we_n[3]) && req_size == 2'd0
        |-> $countones(~ext_we_n) == 1);
endmodule

// File: tb/bus_width_adapter_bench.sv
module bus_width_adapter_bench;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [1:0]    req_size = 2'd0, dev_width = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0]   req_wdata = '0, ext_rdata = '0;
    logic          done, err;
    logic [31:0]   rdata, ext_wdata;
    logic [AW-1:0] ext_addr;
    logic [3:0]    ext_we_n;
    logic          ext_rd_n;

    always #10 clk = ~clk;

    bus_width_adapter #(.AW(AW)) u_bus_width_adapter (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .dev_width(dev_width), .ext_rdata(ext_rdata), .done(done), .err(err),
        .rdata(rdata), .ext_addr(ext_addr), .ext_wdata(ext_wdata),
        .ext_we_n(ext_we_n), .ext_rd_n(ext_rd_n)
    );

    int vectors = 0, miscompares = 0, cycles = 0;
    logic [7:0] mem [64];

    typedef struct {
        logic        rd_n;
        logic [3:0]  we_n;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic        done, err, chk_r;
        logic [31:0] rdata;
        logic [31:0] drive;
        string       tag;
    } exp_t;

    exp_t q[$];

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            miscompares++;
            $display("FAIL watchdog: actual cycles=%0d expected completion", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    function automatic exp_t idle_rec(string t);
        exp_t e;
        e.rd_n = 1'b1; e.we_n = 4'hF; e.addr = '0; e.wdata = '0;
        e.done = 1'b0; e.err = 1'b0; e.chk_r = 1'b0; e.rdata = '0;
        e.drive = '0; e.tag = t;
        return e;
    endfunction

    task automatic check(exp_t e);
        vectors++;
        if ({ext_rd_n, ext_we_n, ext_addr, ext_wdata, done, err} !==
            {e.rd_n, e.we_n, e.addr, e.wdata, e.done, e.err}) begin
            miscompares++;
            $display("FAIL %s: actual rd_n=%b we_n=%b addr=%h wdata=%h done=%b err=%b expected rd_n=%b we_n=%b addr=%h wdata=%h done=%b err=%b",
                     e.tag, ext_rd_n, ext_we_n, ext_addr, ext_wdata, done, err,
                     e.rd_n, e.we_n, e.addr, e.wdata, e.done, e.err);
        end
        if (e.chk_r) begin
            vectors++;
            if (rdata !== e.rdata) begin
                miscompares++;
                $display("FAIL R5: actual rdata=%h expected %h", rdata, e.rdata);
            end
        end
    endtask

    task automatic access(bit wr, logic [1:0] sz, logic [AW-1:0] a, logic [31:0] wd, logic [1:0] dw);
        int acc_b, dev_b, bw, nb;
        bit bad;
        string tg;
        logic [31:0] r;
        acc_b = 1 << sz;
        dev_b = (dw == 2'd3) ? 4 : (1 << dw);
        bad = (sz == 2'd3) || (dw == 2'd3) || ((a % acc_b) != 0);
        bw = (acc_b < dev_b) ? acc_b : dev_b;
        nb = acc_b / bw;
        tg = (dw == 2'd0) ? "R4" : (dw == 2'd1) ? "R3" : (sz == 2'd0) ? "R1" : "R2";
        q.delete();
        if (!bad) begin
            for (int b = 0; b < nb; b++) begin
                exp_t e = idle_rec(tg);
                int ba = a + b * bw;
                int blk = ba - (ba % dev_b);
                e.addr = ba;
                for (int k = 0; k < bw; k++) begin
                    int i = b * bw + k;
                    int ln = dev_b - 1 - ((ba + k) % dev_b);
                    if (wr) begin
                        e.we_n[ln] = 1'b0;
                        e.wdata[8*ln +: 8] = wd[8*(acc_b-1-i) +: 8];
                    end
                end
                if (!wr) begin
                    e.rd_n = 1'b0;
                    for (int ln = 0; ln < 4; ln++)
                        e.drive[8*ln +: 8] = (ln < dev_b) ? mem[(blk + dev_b - 1 - ln) & 63] : 8'h5A;
                end
                q.push_back(e);
                if (b < nb - 1) q.push_back(idle_rec("R7"));
            end
        end
        begin
            exp_t e = idle_rec(bad ? "R8" : "R6");
            e.done = 1'b1;
            e.err = bad;
            r = '0;
            for (int i = 0; i < acc_b; i++) r = (r << 8) | 32'(mem[(a + i) & 63]);
            e.chk_r = !wr && !bad;
            e.rdata = r;
            q.push_back(e);
        end
        @(negedge clk);
        check(idle_rec("R7"));
        req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a;
        req_wdata = wd; dev_width = dw;
        while (q.size() > 0) begin
            exp_t e = q.pop_front();
            @(negedge clk);
            ext_rdata = e.drive;
            check(e);
            if (e.done) req_valid = 1'b0;
        end
        if (wr && !bad)
            for (int i = 0; i < acc_b; i++) mem[(a + i) & 63] = wd[8*(acc_b-1-i) +: 8];
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 8'(8'h11 + 8'(i * 7));
        repeat (2) @(negedge clk);
        begin
            exp_t e = idle_rec("R9");
            e.chk_r = 1'b1;
            check(e);
        end
        rst_n = 1'b1;
        // R1: byte lanes on a 32-bit device, then read the longword back
        for (int k = 0; k < 4; k++) access(1'b1, 2'd0, 32'(8 + k), 32'(8'hC0 + k), 2'd2);
        access(1'b0, 2'd2, 32'd8, '0, 2'd2);
        for (int k = 0; k < 4; k++) access(1'b0, 2'd0, 32'(8 + k), '0, 2'd2);
        // R2: words and longword on a 32-bit device
        access(1'b1, 2'd1, 32'd16, 32'h0000_A1B2, 2'd2);
        access(1'b1, 2'd1, 32'd18, 32'h0000_C3D4, 2'd2);
        access(1'b0, 2'd2, 32'd16, '0, 2'd1);
        access(1'b1, 2'd2, 32'd20, 32'h1234_5678, 2'd2);
        access(1'b0, 2'd1, 32'd22, '0, 2'd2);
        // R3: 16-bit device
        access(1'b1, 2'd0, 32'd24, 32'h0000_00E1, 2'd1);
        access(1'b1, 2'd0, 32'd25, 32'h0000_00E2, 2'd1);
        access(1'b0, 2'd1, 32'd24, '0, 2'd1);
        access(1'b1, 2'd2, 32'd28, 32'h9ABC_DEF0, 2'd1);
        access(1'b0, 2'd2, 32'd28, '0, 2'd0);
        access(1'b0, 2'd0, 32'd21, '0, 2'd1);
        // R4: 8-bit device
        access(1'b1, 2'd1, 32'd32, 32'h0000_7E81, 2'd0);
        access(1'b1, 2'd2, 32'd36, 32'hFEDC_BA98, 2'd0);
        access(1'b0, 2'd1, 32'd32, '0, 2'd1);
        access(1'b0, 2'd2, 32'd36, '0, 2'd0);
        access(1'b0, 2'd0, 32'd23, '0, 2'd0);
        // R8: rejected requests
        access(1'b1, 2'd1, 32'd33, 32'hFFFF_FFFF, 2'd2);
        access(1'b0, 2'd2, 32'd34, '0, 2'd0);
        access(1'b1, 2'd3, 32'd40, 32'hFFFF_FFFF, 2'd2);
        access(1'b0, 2'd0, 32'd40, '0, 2'd3);
        access(1'b0, 2'd2, 32'd36, '0, 2'd2);
        @(negedge clk);
        check(idle_rec("R7"));
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule